// File: doc/BRIEF.md
# Constant-Off-Time Current Limiter

This block is the digital control core of a peak-current regulator for one H-bridge. It receives digitized comparator flags: load current above the regulation limit, high-side short and low-side short. It also receives a flag that says the junction has passed the foldback temperature, and a strobe that marks each output transition. From these it produces three registered outputs. The first asks the bridge to go tri-state. The second selects the reduced threshold for the analog limit comparator. The third is a one-cycle short-circuit pulse for the external fault latch.

When the limit flag is seen, the block removes drive for a fixed off interval and then lets drive resume. After every output transition a blanking interval starts, and the end of an off interval counts as such a transition. During blanking the limit flag is ignored, so a hard short is caught by the short comparators rather than being regulated as a load. Both intervals are counters clocked from the system clock. Their lengths come from a clock rate in MHz and durations in nanoseconds, which default to a 20 µs off interval and a 16.5 µs blanking interval at 50 MHz. Each comparator flag passes a two-sample agreement filter before the block acts on it.

Top module: `ilim_cot_ctrl`

## Requirements
- R1: In reset and on the first cycle after it, `o_tristate`, `o_thr_low` and `o_sc_pulse` are all 0.
- R2: When the filtered limit flag is set outside blanking and no short is present, `o_tristate` rises and stays at 1 for exactly OFF_CYC clock cycles, then returns to 0.
- R3: A 1 on `i_out_edge` starts a blanking window that covers that clock cycle and the next BLANK_CYC-1 cycles. A limit flag that becomes valid inside the window takes effect on the first cycle after the window ends.
- R4: The end of an off interval restarts blanking. With the limit flag held continuously, drive therefore lasts exactly BLANK_CYC cycles between off intervals, which bounds the regulation rate at 1/(OFF_CYC+BLANK_CYC) of the clock. This is about 27 kHz with the defaults.
- R5: A filtered short flag, high-side or low-side, produces exactly one `o_sc_pulse` cycle and sets `o_tristate`. This happens during blanking as well, four clock cycles after the raw flag is applied, which is far inside 8 µs. `o_tristate` stays at 1 while the flag persists. It returns to 0 on the fourth cycle after the raw flag clears, and that release restarts blanking.
- R6: A short takes priority over the limit flag when both are present, and it also acts while an off interval is running.
- R7: `o_thr_low` is 1 (reduced threshold) while the filtered foldback flag is 1 and 0 otherwise, with four cycles from raw input to output.
- R8: Each raw flag takes effect only after two consecutive clock samples agree. A one-cycle pulse on a raw flag has no effect, while a two-cycle pulse is accepted.
- R9: OFF_CYC = CLK_MHZ*OFF_NS/1000 and BLANK_CYC = CLK_MHZ*BLANK_NS/1000, each at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| i_lim_hit | input | 1 | Load current above the regulation limit (raw) |
| i_short_hs | input | 1 | High-side short comparator (raw) |
| i_short_ls | input | 1 | Low-side short comparator (raw) |
| i_temp_fold | input | 1 | Junction above the foldback temperature (raw) |
| i_out_edge | input | 1 | One-cycle strobe marking an output transition |
| o_tristate | output | 1 | Request to put the bridge in tri-state |
| o_thr_low | output | 1 | 1 selects the reduced regulation threshold |
| o_sc_pulse | output | 1 | One-cycle short-circuit fault pulse |

## Verification
The bench builds the block at 50 MHz with OFF_NS=200 and BLANK_NS=160. This gives a 10-cycle off interval and an 8-cycle blanking window, so that one trace of about 60 cycles shows the edge of the window, a full off interval and the re-blanked drive gap that follows it. With windows this short, the onset of the limit flag can be swept over every cycle offset from the strobe until past the window's end. Each sweep point is compared with the arithmetic expectation max(d+3, BLANK_CYC). Shorts are placed inside blanking, together with the limit flag, and during an off interval, and single-cycle and two-cycle glitches are applied to exercise the filter.

// File: rtl/ilim_cot_pkg.sv
package ilim_cot_pkg;

  typedef enum logic [1:0] {
    ST_DRIVE = 2'd0,
    ST_COOL  = 2'd1,
    ST_TRIP  = 2'd2
  } cot_state_e;

  // Converts a duration in ns to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
    int unsigned c;
    c = (mhz * ns) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/cot_flag_filter.sv
module cot_flag_filter #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] clean
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s0, s1, q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s0 <= 1'b0;
        s1 <= 1'b0;
        q  <= 1'b0;
      end else begin
        s0 <= raw[g];
        s1 <= s0;
        if (s0 == s1) q <= s1;
      end
    end
    assign clean[g] = q;
  end

endmodule

// File: rtl/cot_interval_timer.sv
module cot_interval_timer #(
  parameter int unsigned LOAD = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);

  localparam int unsigned W = $clog2(LOAD + 2);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= LOAD_V;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/cot_sequencer.sv
module cot_sequencer
  import ilim_cot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ilim_f,
  input  logic short_f,
  input  logic stb,
  input  logic blank_busy,
  input  logic off_busy,
  output logic off_load,
  output logic restart,
  output logic bridge_off,
  output logic sc_pulse
);

  cot_state_e st, st_n;
  logic pulse_n;
  logic blanking;

  assign blanking = stb | blank_busy;

  always_comb begin
    st_n     = st;
    off_load = 1'b0;
    restart  = 1'b0;
    pulse_n  = 1'b0;
    unique case (st)
      ST_DRIVE: begin
        if (short_f) begin
          st_n    = ST_TRIP;
          pulse_n = 1'b1;
        end else if (ilim_f && !blanking) begin
          st_n     = ST_COOL;
          off_load = 1'b1;
        end
      end
      ST_COOL: begin
        if (short_f) begin
          st_n    = ST_TRIP;
          pulse_n = 1'b1;
        end else if (!off_busy) begin
          st_n    = ST_DRIVE;
          restart = 1'b1;
        end
      end
      ST_TRIP: begin
        if (!short_f) begin
          st_n    = ST_DRIVE;
          restart = 1'b1;
        end
      end
      default: st_n = ST_DRIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_DRIVE;
      bridge_off <= 1'b0;
      sc_pulse   <= 1'b0;
    end else begin
      st         <= st_n;
      bridge_off <= (st_n != ST_DRIVE);
      sc_pulse   <= pulse_n;
    end
  end

endmodule

// File: rtl/ilim_cot_ctrl.sv
module ilim_cot_ctrl #(
  parameter int unsigned CLK_MHZ  = 50,
  parameter int unsigned OFF_NS   = 20000,
  parameter int unsigned BLANK_NS = 16500
) (
  input  logic clk,
  input  logic rst,
  input  logic i_lim_hit,
  input  logic i_short_hs,
  input  logic i_short_ls,
  input  logic i_temp_fold,
  input  logic i_out_edge,
  output logic o_tristate,
  output logic o_thr_low,
  output logic o_sc_pulse
);

  localparam int unsigned OFF_CYC   = ilim_cot_pkg::ns_to_cycles(CLK_MHZ, OFF_NS);
  localparam int unsigned BLANK_CYC = ilim_cot_pkg::ns_to_cycles(CLK_MHZ, BLANK_NS);
  localparam int unsigned NFLAG     = 4;

  logic [NFLAG-1:0] flags_raw, flags_f;
  logic off_load, restart, off_busy, blank_busy;

  assign flags_raw = {i_temp_fold, i_short_ls, i_short_hs, i_lim_hit};

  cot_flag_filter #(.N(NFLAG)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .raw   (flags_raw),
    .clean (flags_f)
  );

  cot_interval_timer #(.LOAD(OFF_CYC - 1)) u_off_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (off_load),
    .busy (off_busy)
  );

  cot_interval_timer #(.LOAD(BLANK_CYC - 1)) u_blank_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (i_out_edge | restart),
    .busy (blank_busy)
  );

  cot_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .ilim_f     (flags_f[0]),
    .short_f    (flags_f[1] | flags_f[2]),
    .stb        (i_out_edge),
    .blank_busy (blank_busy),
    .off_busy   (off_busy),
    .off_load   (off_load),
    .restart    (restart),
    .bridge_off (o_tristate),
    .sc_pulse   (o_sc_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) o_thr_low <= 1'b0;
    else     o_thr_low <= flags_f[3];
  end

endmodule

// File: rtl/ilim_cot_chk.sv
module ilim_cot_chk #(
  parameter int unsigned CLK_MHZ  = 50,
  parameter int unsigned OFF_NS   = 20000,
  parameter int unsigned BLANK_NS = 16500
) (
  input logic clk,
  input logic rst,
  input logic o_tristate,
  input logic o_sc_pulse
);

  localparam int unsigned OFF_CYC   = ilim_cot_pkg::ns_to_cycles(CLK_MHZ, OFF_NS);
  localparam int unsigned BLANK_CYC = ilim_cot_pkg::ns_to_cycles(CLK_MHZ, BLANK_NS);

  int unsigned run_len, low_len;
  logic fault_run, after_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len   <= 0;
      low_len   <= 0;
      fault_run <= 1'b0;
      after_off <= 1'b0;
    end else begin
      run_len   <= o_tristate ? ((run_len > OFF_CYC) ? run_len : run_len + 1) : 0;
      low_len   <= o_tristate ? 0 : ((low_len > BLANK_CYC) ? low_len : low_len + 1);
      fault_run <= o_tristate ? (fault_run | o_sc_pulse) : 1'b0;
      after_off <= o_tristate ? !(fault_run | o_sc_pulse) : after_off;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    o_sc_pulse |=> !o_sc_pulse); // R5
  AST_PULSE_TRISTATE: assert property (@(posedge clk) disable iff (rst)
    o_sc_pulse |-> o_tristate); // R5
  AST_OFF_SPAN: assert property (@(posedge clk) disable iff (rst)
    ($fell(o_tristate) && !fault_run) |-> (run_len == OFF_CYC)); // R2
  AST_RATE_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(o_tristate) && !o_sc_pulse && after_off) |-> (low_len >= BLANK_CYC)); // R4

endmodule

bind ilim_cot_ctrl ilim_cot_chk #(
  .CLK_MHZ  (CLK_MHZ),
  .OFF_NS   (OFF_NS),
  .BLANK_NS (BLANK_NS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .o_tristate (o_tristate),
  .o_sc_pulse (o_sc_pulse)
);

// File: tb/ilim_cot_ctrl_tb.sv
module ilim_cot_ctrl_tb;

  localparam int unsigned CLK_MHZ  = 50;
  localparam int unsigned OFF_NS   = 200;
  localparam int unsigned BLANK_NS = 160;
  localparam int OFF   = CLK_MHZ * OFF_NS / 1000;   // R9: 10
  localparam int BLANK = CLK_MHZ * BLANK_NS / 1000; // R9: 8
  localparam int TR    = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lim = 1'b0, shs = 1'b0, sls = 1'b0, hot = 1'b0, stb = 1'b0;
  logic o_tristate, o_thr_low, o_sc_pulse;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic tr_off [TR];
  logic tr_pls [TR];
  logic tr_thr [TR];

  always #10 clk = ~clk;

  ilim_cot_ctrl #(.CLK_MHZ(CLK_MHZ), .OFF_NS(OFF_NS), .BLANK_NS(BLANK_NS)) u_dut (
    .clk(clk), .rst(rst), .i_lim_hit(lim), .i_short_hs(shs), .i_short_ls(sls),
    .i_temp_fold(hot), .i_out_edge(stb),
    .o_tristate(o_tristate), .o_thr_low(o_thr_low), .o_sc_pulse(o_sc_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lim = 0; shs = 0; sls = 0; hot = 0; stb = 0;
    repeat (30) @(negedge clk);
  endtask

  // Each raw input is 1 for trace indices in [from, to); index 0 is the
  // first driven cycle. Samples are taken at the negedge before driving.
  task automatic run(input int n, input int stb_at,
                     input int l0, input int l1, input int h0, input int h1,
                     input int w0, input int w1, input int t0, input int t1);
    for (int i = 0; i < TR; i++) begin
      tr_off[i] = 0; tr_pls[i] = 0; tr_thr[i] = 0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tr_off[i] = o_tristate;
      tr_pls[i] = o_sc_pulse;
      tr_thr[i] = o_thr_low;
      stb = (i == stb_at);
      lim = (i >= l0 && i < l1);
      shs = (i >= h0 && i < h1);
      sls = (i >= w0 && i < w1);
      hot = (i >= t0 && i < t1);
    end
  endtask

  function automatic int first_high_off(input int from);
    for (int i = from; i < TR; i++) if (tr_off[i]) return i;
    return -1;
  endfunction

  function automatic int first_low_off(input int from);
    for (int i = from; i < TR; i++) if (!tr_off[i]) return i;
    return -1;
  endfunction

  function automatic int count_ones(input int which);
    int c = 0;
    for (int i = 0; i < TR; i++)
      c += (which == 0) ? int'(tr_off[i]) : (which == 1) ? int'(tr_pls[i]) : int'(tr_thr[i]);
    return c;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(o_tristate == 0 && o_thr_low == 0 && o_sc_pulse == 0, "R1 outputs in reset",
        {o_tristate, o_thr_low, o_sc_pulse}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(o_tristate == 0 && o_thr_low == 0 && o_sc_pulse == 0, "R1 outputs after reset",
        {o_tristate, o_thr_low, o_sc_pulse}, 0);

    // R3 sweep of limit onset relative to the transition strobe
    for (int d = 0; d <= 11; d++) begin
      int r, f, g, exp_r;
      idle();
      run(60, 0, d, 60, 99, 99, 99, 99, 99, 99);
      exp_r = ((d + 3 > BLANK) ? d + 3 : BLANK) + 1;
      r = first_high_off(0);
      chk(r == exp_r, $sformatf("R3 first off at onset %0d", d), r, exp_r);
      f = first_low_off(r);
      chk(f - r == OFF, $sformatf("R2 R9 off span at onset %0d", d), f - r, OFF);
      g = first_high_off(f);
      chk(g - f == BLANK, $sformatf("R4 drive gap at onset %0d", d), g - f, BLANK);
    end

    // R8: one-cycle limit glitch is ignored, two-cycle pulse is taken
    idle();
    run(24, -1, 0, 1, 99, 99, 99, 99, 99, 99);
    chk(count_ones(0) == 0, "R8 one-cycle limit glitch", count_ones(0), 0);
    idle();
    run(24, -1, 0, 2, 99, 99, 99, 99, 99, 99);
    chk(first_high_off(0) == 4, "R8 two-cycle limit pulse", first_high_off(0), 4);
    chk(count_ones(0) == OFF, "R2 off span from short pulse", count_ones(0), OFF);

    // R7: threshold select follows the foldback flag
    idle();
    run(24, -1, 99, 99, 99, 99, 99, 99, 0, 10);
    chk(tr_thr[3] == 0 && tr_thr[4] == 1, "R7 threshold rise at index 4",
        {tr_thr[3], tr_thr[4]}, 1);
    chk(count_ones(2) == 10 && tr_thr[14] == 0, "R7 threshold high span", count_ones(2), 10);
    idle();
    run(24, -1, 99, 99, 99, 99, 99, 99, 0, 1);
    chk(count_ones(2) == 0, "R8 one-cycle foldback glitch", count_ones(2), 0);

    // R5: high-side short inside blanking
    idle();
    run(30, 0, 99, 99, 0, 12, 99, 99, 99, 99);
    chk(tr_pls[4] == 1 && count_ones(1) == 1, "R5 single pulse at index 4",
        count_ones(1), 1);
    chk(first_high_off(0) == 4, "R5 tri-state at index 4", first_high_off(0), 4);
    chk(first_low_off(4) == 16, "R5 release index", first_low_off(4), 16);

    // R6: low-side short together with limit flag
    idle();
    run(30, -1, 0, 30, 99, 99, 0, 5, 99, 99);
    chk(tr_pls[4] == 1 && count_ones(1) == 1, "R6 short wins over limit", count_ones(1), 1);
    chk(first_low_off(4) == 9, "R5 R6 release after short clears", first_low_off(4), 9);
    chk(first_high_off(9) == 17, "R4 blanking after short release", first_high_off(9), 17);

    // R6: short arriving during an off interval
    idle();
    run(30, -1, 0, 30, 99, 99, 6, 30, 99, 99);
    chk(tr_pls[10] == 1 && count_ones(1) == 1, "R6 pulse during off interval",
        count_ones(1), 1);
    chk(tr_off[20] == 1 && tr_off[29] == 1, "R6 tri-state held past off interval",
        {tr_off[20], tr_off[29]}, 3);

    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule